// File: doc/BRIEF.md
# Multiplexed-Bus ROM Read Sequencer

This block is a bus master for reading bytes out of a self-decoding ROM. The ROM is attached to a processor-style bus that shares one 8-bit address path between the two halves of the address. The block drives that bus's timing lines itself: a high-address latch pulse, a low-address strobe pulse and an active-low read strobe. For each byte it runs a fixed handshake of nine steps. The high address byte is put on the bus and latched, the read strobe drops, and then the low address byte is put on the bus and strobed. The data byte is sampled after that, and the read strobe is released.

A request gives a start address and a byte count. The block then reads that many consecutive bytes and presents each one with a one-clock valid pulse. A typical request dumps the 1 KiB window from 0x0400 to 0x07FF. Every handshake step is held for a fixed number of clocks, so slow parts can be met; at 50 MHz a few microseconds is a few hundred clocks. After reset the block waits through a long settle period before it accepts any request. Both times are parameters, so a simulation can make them short.

Top module: `rom_fetch_sequencer`

## Requirements
- R1: During reset and through the settle period after it, the high-address latch, the low-address strobe, the valid pulse and done are 0 and the read strobe is 1. The settle period lasts SETTLE_CYCLES clocks after reset is released, and a start pulse during it is ignored. A start held high from reset release gives a first rising edge of the high-address latch SETTLE_CYCLES+STEP_CYCLES+1 clocks after release.
- R2: While idle, the high-address latch and the low-address strobe are 0 and the read strobe is 1.
- R3: Each byte begins with the address bits [15:8] on the bus. The high-address latch then rises while the read strobe is still 1, the read strobe falls while the latch is 1, and the latch then falls.
- R4: Next the address bits [7:0] are put on the bus. The low-address strobe then pulses high while the read strobe is 0 and the latch is 0, and the bus address does not change while the strobe is high.
- R5: The data bus is captured one step after the low-address strobe falls, while the read strobe is still 0. The captured byte appears on the data output with a valid pulse exactly one clock wide, and the read strobe rises one step later.
- R6: Every step lasts exactly STEP_CYCLES clocks. The latch is high for 2 steps, the low-address strobe for 1 step and the read strobe is low for 6 steps, and consecutive latch rising edges are 9 steps apart.
- R7: The address advances by one after each byte, with a carry from bits [7:0] into bits [15:8], so the bytes arrive in ascending address order.
- R8: After the requested number of bytes, done goes to 1 and stays at 1 until the next start is accepted. It is 0 for the whole of a run.
- R9: A start with a count of zero sets done on the next clock and causes no bus cycle.
- R10: A start pulse while a run is in progress is ignored; the current run keeps its address and its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, taken while idle |
| start_addr_i | input | 16 | First byte address of the request |
| byte_count_i | input | COUNT_W | Number of bytes to read |
| bus_data_i | input | 8 | Data bus from the ROM |
| bus_addr_o | output | 8 | Multiplexed address bus |
| hi_latch_o | output | 1 | High-address latch pulse (TPA) |
| lo_strobe_o | output | 1 | Low-address strobe pulse (TPB) |
| rd_n_o | output | 1 | Active-low read strobe |
| data_o | output | 8 | Last captured byte |
| data_vld_o | output | 1 | One-clock pulse marking a new byte on data_o |
| done_o | output | 1 | Level, set when the requested count has been read |

## Verification
The embedded properties check the ordering of the bus handshake on every cycle. The latch must rise before the read strobe falls, the low-address strobe may pulse only inside the read with the address held steady, and the valid pulse is one clock wide and falls inside the read. They also check that the lines are quiet at idle and during settle, and that done appears only when idle. Some behaviours need a scenario from the bench to show them. These are the exact length of each step and of each pulse, and the length of the settle period. They also include the data bytes returned from a ROM model that latches the high byte on the latch's falling edge, the address carry, and the end of a run after the requested count. The last group is the ignoring of a start during settle or during a run, and the zero-count request.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [3:0] {
    PH_SETTLE,
    PH_IDLE,
    PH_HI_ADDR,
    PH_TPA_RISE,
    PH_RD_FALL,
    PH_TPA_FALL,
    PH_LO_ADDR,
    PH_TPB_RISE,
    PH_TPB_FALL,
    PH_CAPTURE,
    PH_RD_RISE
  } phase_e;

  typedef struct packed {
    logic hi_sel;
    logic lo_sel;
    logic tpa;
    logic tpb;
    logic rd_n;
  } pins_t;

  // Bus line levels held during each phase.
  function automatic pins_t pins_of(phase_e p);
    pins_t r;
    r = '{hi_sel: 1'b0, lo_sel: 1'b0, tpa: 1'b0, tpb: 1'b0, rd_n: 1'b1};
    case (p)
      PH_HI_ADDR:  r.hi_sel = 1'b1;
      PH_TPA_RISE: begin r.hi_sel = 1'b1; r.tpa = 1'b1; end
      PH_RD_FALL:  begin r.hi_sel = 1'b1; r.tpa = 1'b1; r.rd_n = 1'b0; end
      PH_TPA_FALL: begin r.hi_sel = 1'b1; r.rd_n = 1'b0; end
      PH_LO_ADDR:  begin r.lo_sel = 1'b1; r.rd_n = 1'b0; end
      PH_TPB_RISE: begin r.lo_sel = 1'b1; r.tpb = 1'b1; r.rd_n = 1'b0; end
      PH_TPB_FALL: begin r.lo_sel = 1'b1; r.rd_n = 1'b0; end
      PH_CAPTURE:  begin r.lo_sel = 1'b1; r.rd_n = 1'b0; end
      PH_RD_RISE:  r.lo_sel = 1'b1;
      default:     ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rfs_dwell_timer.sv
module rfs_dwell_timer #(
  parameter int W        = 8,
  parameter int RST_LOAD = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= W'(RST_LOAD);
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R6: when not reloaded, an expired timer stays expired
  a_r6_expired_holds: assert property (@(posedge clk) disable iff (rst)
    (expired_o && !load_i) |=> expired_o);

endmodule

// File: rtl/rfs_addr_track.sv
module rfs_addr_track #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] count_i,
  output logic [AW-1:0] addr_nxt_o,
  output logic          last_o
);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] left_q, left_nxt;

  always_comb begin
    addr_nxt_o = addr_q;
    left_nxt   = left_q;
    if (load_i) begin
      addr_nxt_o = base_i;
      left_nxt   = count_i;
    end else if (step_i) begin
      addr_nxt_o = addr_q + 1'b1;
      left_nxt   = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      left_q <= '0;
    end else begin
      addr_q <= addr_nxt_o;
      left_q <= left_nxt;
    end
  end

  assign last_o = (left_q == CW'(1));

  // R7: a step moves the address forward by exactly one
  a_r7_addr_steps_by_one: assert property (@(posedge clk) disable iff (rst)
    (step_i && !load_i) |=> (addr_q == $past(addr_q) + 1'b1));

endmodule

// File: rtl/rom_fetch_sequencer.sv
module rom_fetch_sequencer
  import rfs_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int COUNT_W       = 16,
  parameter int STEP_CYCLES   = 200,
  parameter int SETTLE_CYCLES = 100_000_000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [2*DATA_W-1:0]  start_addr_i,
  input  logic [COUNT_W-1:0]   byte_count_i,
  input  logic [DATA_W-1:0]    bus_data_i,
  output logic [DATA_W-1:0]    bus_addr_o,
  output logic                 hi_latch_o,
  output logic                 lo_strobe_o,
  output logic                 rd_n_o,
  output logic [DATA_W-1:0]    data_o,
  output logic                 data_vld_o,
  output logic                 done_o
);

  localparam int ADDR_W  = 2 * DATA_W;
  localparam int LONGEST = (SETTLE_CYCLES > STEP_CYCLES) ? SETTLE_CYCLES : STEP_CYCLES;
  localparam int TMR_W   = $clog2(LONGEST + 1);

  phase_e ph_q, ph_nxt;
  logic t_load, t_exp, a_load, a_step, a_last, vld_nxt, done_set, done_clr;
  logic [ADDR_W-1:0] addr_nxt;
  pins_t pn;

  rfs_dwell_timer #(.W(TMR_W), .RST_LOAD(SETTLE_CYCLES - 1)) u_timer (
    .clk(clk), .rst(rst), .load_i(t_load),
    .load_val_i(TMR_W'(STEP_CYCLES - 1)), .expired_o(t_exp));

  rfs_addr_track #(.AW(ADDR_W), .CW(COUNT_W)) u_addr (
    .clk(clk), .rst(rst), .load_i(a_load), .step_i(a_step),
    .base_i(start_addr_i), .count_i(byte_count_i),
    .addr_nxt_o(addr_nxt), .last_o(a_last));

  always_comb begin
    ph_nxt   = ph_q;
    t_load   = 1'b0;
    a_load   = 1'b0;
    a_step   = 1'b0;
    vld_nxt  = 1'b0;
    done_set = 1'b0;
    done_clr = 1'b0;
    case (ph_q)
      PH_SETTLE: if (t_exp) ph_nxt = PH_IDLE;
      PH_IDLE: if (start_i) begin
        if (byte_count_i == '0) done_set = 1'b1;
        else begin
          a_load   = 1'b1;
          done_clr = 1'b1;
          t_load   = 1'b1;
          ph_nxt   = PH_HI_ADDR;
        end
      end
      PH_RD_RISE: if (t_exp) begin
        if (a_last) begin
          done_set = 1'b1;
          ph_nxt   = PH_IDLE;
        end else begin
          a_step = 1'b1;
          t_load = 1'b1;
          ph_nxt = PH_HI_ADDR;
        end
      end
      default: if (t_exp) begin
        ph_nxt  = phase_e'(ph_q + 4'd1);
        t_load  = 1'b1;
        vld_nxt = (ph_q == PH_TPB_FALL);
      end
    endcase
  end

  assign pn = pins_of(ph_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q        <= PH_SETTLE;
      bus_addr_o  <= '0;
      hi_latch_o  <= 1'b0;
      lo_strobe_o <= 1'b0;
      rd_n_o      <= 1'b1;
      data_o      <= '0;
      data_vld_o  <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      ph_q        <= ph_nxt;
      hi_latch_o  <= pn.tpa;
      lo_strobe_o <= pn.tpb;
      rd_n_o      <= pn.rd_n;
      if (pn.hi_sel)      bus_addr_o <= addr_nxt[ADDR_W-1:DATA_W];
      else if (pn.lo_sel) bus_addr_o <= addr_nxt[DATA_W-1:0];
      else                bus_addr_o <= '0;
      data_vld_o <= vld_nxt;
      if (vld_nxt) data_o <= bus_data_i;
      if (done_set)      done_o <= 1'b1;
      else if (done_clr) done_o <= 1'b0;
    end
  end

  // R1: settle period keeps every output quiet
  a_r1_settle_quiet: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_SETTLE) |-> (!done_o && !data_vld_o && !hi_latch_o && rd_n_o));
  // R2: idle line levels
  a_r2_idle_levels: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_IDLE) |-> (!hi_latch_o && !lo_strobe_o && rd_n_o));
  // R3: latch rises before the read begins
  a_r3_latch_before_read: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_latch_o) |-> rd_n_o);
  // R3: read strobe falls under the latch
  a_r3_read_under_latch: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n_o) |-> hi_latch_o);
  // R4: low strobe only inside the read, after the latch dropped
  a_r4_strobe_in_read: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_strobe_o) |-> (!rd_n_o && !hi_latch_o));
  // R4: address steady while the low strobe is high
  a_r4_addr_steady: assert property (@(posedge clk) disable iff (rst)
    lo_strobe_o |-> $stable(bus_addr_o));
  // R5: valid is a single-clock pulse
  a_r5_vld_single: assert property (@(posedge clk) disable iff (rst)
    data_vld_o |=> !data_vld_o);
  // R5: capture happens inside the read, after the strobe
  a_r5_vld_in_read: assert property (@(posedge clk) disable iff (rst)
    data_vld_o |-> (!rd_n_o && !lo_strobe_o));
  // R8: done only while idle
  a_r8_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (ph_q == PH_IDLE));

endmodule

// File: tb/rom_fetch_sequencer_tb_top.sv
`timescale 1ns/1ps
module rom_fetch_sequencer_tb_top;

  localparam int STEP   = 3;
  localparam int SETTLE = 25;
  localparam int CW     = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [15:0] s_addr = '0;
  logic [CW-1:0] s_cnt = '0;
  logic [7:0] bus_data, bus_addr, data;
  logic tpa, tpb, rd_n, vld, done;

  always #10 clk = ~clk;

  rom_fetch_sequencer #(.DATA_W(8), .COUNT_W(CW), .STEP_CYCLES(STEP),
    .SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .start_addr_i(s_addr),
    .byte_count_i(s_cnt), .bus_data_i(bus_data), .bus_addr_o(bus_addr),
    .hi_latch_o(tpa), .lo_strobe_o(tpb), .rd_n_o(rd_n), .data_o(data),
    .data_vld_o(vld), .done_o(done));

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  function automatic logic [7:0] rom_fn(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ROM model: high byte latched on the falling edge of the latch line
  logic [7:0] hi_lat = '0;
  assign bus_data = rd_n ? 8'hC3 : rom_fn({hi_lat, bus_addr});

  always @(posedge clk) cyc <= cyc + 1;

  // Protocol monitor, sampled between edges
  logic [15:0] exp_addr = '0;
  int got = 0, vld_total = 0, rd_events = 0;
  bit p_tpa = 0, p_tpb = 0, p_rd_n = 1, p_vld = 0, seen_rise = 0;
  int rise_cyc, tpb_cyc, rd_cyc;

  always @(negedge clk) begin
    if (!rst) begin
      if (tpa && !p_tpa) begin
        chk(rd_n == 1'b1, "R3 latch rise with read high", rd_n, 1);
        chk(bus_addr == exp_addr[15:8], "R3 high address byte", bus_addr, exp_addr[15:8]);
        if (seen_rise) chk(cyc - rise_cyc == 9*STEP, "R6 byte period", cyc - rise_cyc, 9*STEP);
        seen_rise = 1; rise_cyc = cyc;
      end
      if (!tpa && p_tpa) begin
        chk(cyc - rise_cyc == 2*STEP, "R6 latch width", cyc - rise_cyc, 2*STEP);
        hi_lat = bus_addr;
      end
      if (!rd_n && p_rd_n) begin
        chk(tpa == 1'b1, "R3 read falls under latch", tpa, 1);
        rd_cyc = cyc; rd_events++;
      end
      if (tpb && !p_tpb) begin
        chk(!rd_n && !tpa, "R4 strobe inside read", {rd_n, tpa}, 0);
        chk(bus_addr == exp_addr[7:0], "R4 low address byte", bus_addr, exp_addr[7:0]);
        tpb_cyc = cyc;
      end
      if (!tpb && p_tpb) chk(cyc - tpb_cyc == STEP, "R6 strobe width", cyc - tpb_cyc, STEP);
      if (rd_n && !p_rd_n) chk(cyc - rd_cyc == 6*STEP, "R5 R6 read width", cyc - rd_cyc, 6*STEP);
      if (vld) begin
        chk(!p_vld, "R5 valid one clock", p_vld, 0);
        chk(!rd_n, "R5 capture before read release", rd_n, 0);
        chk(data == rom_fn(exp_addr), "R5 R7 data byte", data, rom_fn(exp_addr));
        exp_addr = exp_addr + 1'b1;
        got++; vld_total++;
      end
    end
    p_tpa = tpa; p_tpb = tpb; p_rd_n = rd_n; p_vld = vld;
  end

  task automatic pulse_start(input logic [15:0] a, input int n);
    @(negedge clk);
    start = 1'b1; s_addr = a; s_cnt = CW'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input logic [15:0] a, input int n, input bit inject);
    int guard = 0;
    exp_addr = a; got = 0; seen_rise = 0;
    pulse_start(a, n);
    if (inject) begin
      repeat (5*STEP) @(negedge clk);
      pulse_start(16'h0700, 5);
    end
    while (!done && guard < 20*STEP*(n+2)) begin @(negedge clk); guard++; end
    chk(done == 1'b1, "R8 done after run", done, 1);
    chk(got == n, inject ? "R10 count unchanged by start" : "R8 byte count", got, n);
    repeat (10) @(negedge clk);
    chk(done == 1'b1 && got == n, "R8 done holds", {done, got[7:0]}, {1'b1, n[7:0]});
  endtask

  task automatic do_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(!tpa && !tpb && rd_n && !vld && !done, "R1 reset levels",
        {tpa, tpb, rd_n, vld, done}, 5'b00100);
  endtask

  initial begin
    int n, v, seed_init;
    seed_init = $urandom(32'd2024);
    do_reset();
    // R1: start during settle is ignored
    rst = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1; s_addr = 16'h0400; s_cnt = 2;
    @(negedge clk); start = 1'b0;
    repeat (SETTLE + 20*STEP) @(negedge clk);
    chk(rd_events == 0 && vld_total == 0 && !done, "R1 settle ignores start",
        rd_events + vld_total, 0);
    chk(!tpa && !tpb && rd_n, "R2 idle levels", {tpa, tpb, rd_n}, 3'b001);
    // R9: zero count
    v = rd_events;
    pulse_start(16'h0400, 0);
    chk(done == 1'b1, "R9 zero count done", done, 1);
    repeat (4*STEP) @(negedge clk);
    chk(rd_events == v, "R9 no bus cycle", rd_events, v);
    // R1/R6: settle length with start held from release
    do_reset();
    exp_addr = 16'h0400; got = 0; seen_rise = 0;
    start = 1'b1; s_addr = 16'h0400; s_cnt = 1;
    @(negedge clk); rst = 1'b0;
    n = 0;
    while (!tpa && n < SETTLE + 20*STEP) begin @(posedge clk); n++; #1; end
    start = 1'b0;
    chk(n == SETTLE + STEP + 1, "R1 settle length", n, SETTLE + STEP + 1);
    v = 0;
    while (!done && v < 20*STEP) begin @(negedge clk); v++; end
    chk(got == 1, "R8 single byte run", got, 1);
    // Directed corners
    run(16'h04FE, 4, 0);   // R7 carry into high byte
    run(16'h07FF, 1, 0);   // end of window
    run(16'h0400, 3, 1);   // R10 start during run
    // Constrained random runs inside the window
    for (int i = 0; i < 10; i++) begin
      logic [15:0] a;
      a = 16'h0400 + 16'($urandom_range(0, 16'h03FF));
      run(a, $urandom_range(1, 8), 0);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule